// File: doc/BRIEF.md
# Iterative Indexed-Indirect Address Generator

This block turns the address part of a 36-bit instruction word into an 18-bit effective address E. The address part has three fields: an 18-bit offset, a 4-bit index selector and an indirect flag. A nonzero selector adds the low half of one of sixteen accumulators to the offset. Selector zero means no indexing, so accumulator 0 is never used as an index. When the indirect flag is set, the sum is not the result. It is the address of a further word in memory. That word is read over a valid/ready port and decoded with the same three fields. Each new level may index through a different accumulator. The walk stops at the first word whose indirect flag is clear.

The calculation is the same for every instruction, including instructions that use E as a value rather than as an address. A chain of indirect words can point back to itself and run forever. An abort input therefore ends the walk at any fetch decision. The block then gives an aborted pulse and produces no result. A saturating counter reports how many indirect words the last walk fetched.

The controller has four states. IDLE waits for a start. RESOLVE forms the modified address from the current word. ISSUE presents the memory request. AWAIT waits for the read data. The transitions are:
- IDLE→RESOLVE on accept.
- RESOLVE→IDLE on finish (flag clear) or on abort.
- RESOLVE→ISSUE on chase.
- ISSUE→IDLE on withdraw (abort).
- ISSUE→AWAIT on handshake.
- AWAIT→RESOLVE on reply.

Top module: `ea_chain_unit`

## Requirements
- R1: Counting bit positions from the LSB as 0, the offset is bits 17:0, the index selector is bits 21:18 and the indirect flag is bit 22. Bits 35:23 are ignored, both in the instruction word and in every fetched word.
- R2: With selector 0, the modified address equals the offset, and no accumulator content has any effect. This includes accumulator 0.
- R3: With selector 1 to 15, the modified address is the offset plus bits 17:0 of that accumulator, modulo 2^18. Accumulator bits 35:18 are ignored.
- R4: When the current word has the flag clear, E becomes the modified address and done_o pulses high for exactly one cycle. For an unindexed or indexed instruction with the flag clear, done_o is high in the second cycle after the cycle in which start is accepted.
- R5: When the flag is set, a read is requested at the modified address. The returned word is decoded again, with its own selector. This repeats until a word with the flag clear is reached.
- R6: Once raised, a read request holds its address until it is accepted or withdrawn by abort. Only one read is outstanding at a time, and no request is raised while a reply is awaited.
- R7: abort_i is sampled when a fetch is about to be decided (flag set in RESOLVE) and while a request waits in ISSUE. An abort at either point withdraws the request and ends the walk. aborted_o then pulses for one cycle, done_o does not pulse, and ea_o keeps its prior value. abort_i has no effect on a word whose flag is clear.
- R8: ea_o changes only in the cycle in which done_o is high, and holds its value otherwise.
- R9: levels_o is cleared when start is accepted and counts the indirect words fetched. It saturates at 2^LVL_W-1.
- R10: After reset, busy_o, done_o, aborted_o and mem_req_valid_o are low, and ea_o and levels_o are zero.
- R11: start_i is ignored while busy_o is high.
- R12: busy_o rises in the cycle after a start is accepted and falls in the cycle in which done_o or aborted_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calculation on instr_i (taken in IDLE) |
| instr_i | input | 36 | Instruction word |
| abort_i | input | 1 | Interrupt request that ends a chain |
| acc_sel_o | output | 4 | Accumulator index, read combinationally |
| acc_data_i | input | 36 | Contents of the selected accumulator |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 18 | Read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 36 | Fetched indirect word |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| aborted_o | output | 1 | One-cycle abort pulse |
| ea_o | output | 18 | Effective address E |
| levels_o | output | 8 | Indirect words fetched by the last walk |

## Verification
The bench builds the block with its defaults: an 18-bit address, a 4-bit selector and an 8-bit level counter. With an 8-bit counter, a self-referencing word reaches counter saturation in under a thousand cycles, before abort is raised. The 18-bit width makes the wrap of the index sum reachable with a single large accumulator value. The bench memory decodes only six address bits, so random chains fold onto a small table. This produces deep chains and real loops, which the reference model detects and turns into abort cases.

// File: rtl/ea_chain_pkg.sv
package ea_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_ISSUE   = 2'd2,
        ST_AWAIT   = 2'd3
    } ea_state_e;

endpackage

// File: rtl/ea_field_split.sv
module ea_field_split #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int IDX_W  = 4
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              ind_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] ofs_o
);
    localparam int IND_POS = ADDR_W + IDX_W;

    // Bits above the indirect flag carry opcode/accumulator and are ignored.
    logic unused_hi;
    assign unused_hi = ^word_i[WORD_W-1:IND_POS+1];

    assign ofs_o = word_i[ADDR_W-1:0];
    assign idx_o = word_i[IND_POS-1:ADDR_W];
    assign ind_o = word_i[IND_POS];
endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] ofs_i,
    output logic [IDX_W-1:0]  acc_sel_o,
    input  logic [WORD_W-1:0] acc_data_i,
    output logic [ADDR_W-1:0] mod_o
);
    logic              use_idx;
    logic [ADDR_W-1:0] addend;
    logic              unused_acc_hi;

    assign acc_sel_o     = idx_i;
    assign use_idx       = (idx_i != '0);
    assign unused_acc_hi = ^acc_data_i[WORD_W-1:ADDR_W];

    always_comb begin
        addend = use_idx ? acc_data_i[ADDR_W-1:0] : '0;
        mod_o  = ofs_i + addend;   // carry out discarded
    end
endmodule

// File: rtl/ea_level_count.sv
module ea_level_count #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [LVL_W-1:0] count_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i && (count_o != LVL_MAX)) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/ea_chain_unit.sv
module ea_chain_unit
    import ea_chain_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int IDX_W  = 4,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic              abort_i,
    output logic [IDX_W-1:0]  acc_sel_o,
    input  logic [WORD_W-1:0] acc_data_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              aborted_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [LVL_W-1:0]  levels_o
);
    localparam int REF_W = 1 + IDX_W + ADDR_W;

    typedef struct packed {
        logic              ind;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] ofs;
    } ea_ref_t;

    ea_state_e         state_q, state_d;
    ea_ref_t           cur_q, ins_ref, rsp_ref;
    logic [ADDR_W-1:0] mod_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ea_q;
    logic              done_q, aborted_q;
    logic              accept, reply;

    ea_field_split #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_ins (
        .word_i (instr_i),
        .ind_o  (ins_ref.ind),
        .idx_o  (ins_ref.idx),
        .ofs_o  (ins_ref.ofs)
    );

    ea_field_split #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_rsp (
        .word_i (mem_rsp_data_i),
        .ind_o  (rsp_ref.ind),
        .idx_o  (rsp_ref.idx),
        .ofs_o  (rsp_ref.ofs)
    );

    ea_index_add #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
        .idx_i      (cur_q.idx),
        .ofs_i      (cur_q.ofs),
        .acc_sel_o  (acc_sel_o),
        .acc_data_i (acc_data_i),
        .mod_o      (mod_addr)
    );

    assign accept = (state_q == ST_IDLE) && start_i;
    assign reply  = (state_q == ST_AWAIT) && mem_rsp_valid_i;

    ea_level_count #(.LVL_W(LVL_W)) u_levels (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .inc_i   (reply),
        .count_o (levels_o)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RESOLVE;              // accept
            end
            ST_RESOLVE: begin
                if (!cur_q.ind)   state_d = ST_IDLE;            // finish
                else if (abort_i) state_d = ST_IDLE;            // abort
                else              state_d = ST_ISSUE;           // chase
            end
            ST_ISSUE: begin
                if (abort_i)              state_d = ST_IDLE;    // withdraw
                else if (mem_req_ready_i) state_d = ST_AWAIT;   // handshake
            end
            ST_AWAIT: begin
                if (mem_rsp_valid_i) state_d = ST_RESOLVE;      // reply
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            addr_q    <= '0;
            ea_q      <= '0;
            done_q    <= 1'b0;
            aborted_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            aborted_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) cur_q <= ins_ref;
                end
                ST_RESOLVE: begin
                    if (!cur_q.ind) begin
                        ea_q   <= mod_addr;
                        done_q <= 1'b1;
                    end else if (abort_i) begin
                        aborted_q <= 1'b1;
                    end else begin
                        addr_q <= mod_addr;
                    end
                end
                ST_ISSUE: begin
                    if (abort_i) aborted_q <= 1'b1;
                end
                ST_AWAIT: begin
                    if (mem_rsp_valid_i) cur_q <= rsp_ref;
                end
                default: ;
            endcase
        end
    end

    assign mem_req_valid_o = (state_q == ST_ISSUE) && !abort_i;
    assign mem_addr_o      = addr_q;
    assign busy_o          = (state_q != ST_IDLE);
    assign done_o          = done_q;
    assign aborted_o       = aborted_q;
    assign ea_o            = ea_q;

    logic unused_ref_w;
    assign unused_ref_w = (REF_W == 0);
endmodule

// File: rtl/ea_chain_checks.sv
module ea_chain_checks #(
    parameter int ADDR_W = 18,
    parameter int LVL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rsp_valid_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              aborted_o,
    input logic [ADDR_W-1:0] ea_o,
    input logic [LVL_W-1:0]  levels_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    logic outstanding;
    always_ff @(posedge clk) begin
        if (!rst_n)                                outstanding <= 1'b0;
        else if (mem_req_valid_o && mem_req_ready_i) outstanding <= 1'b1;
        else if (mem_rsp_valid_i)                  outstanding <= 1'b0;
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |=> !aborted_o);

    assert_done_excl_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && aborted_o));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (abort_i || (mem_req_valid_o && $stable(mem_addr_o))));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid_o);

    assert_ea_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_o != $past(ea_o)) |-> done_o);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_valid_o);

    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_lvl_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && levels_o == LVL_MAX) |=> (levels_o == LVL_MAX));
endmodule

bind ea_chain_unit ea_chain_checks #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .abort_i         (abort_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .aborted_o       (aborted_o),
    .ea_o            (ea_o),
    .levels_o        (levels_o)
);

// File: tb/ea_chain_unit_bench.sv
`timescale 1ns/1ps
module ea_chain_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [35:0] instr_i = '0;
    logic        abort_i = 1'b0;
    logic [3:0]  acc_sel_o;
    logic [35:0] acc_data_i;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [17:0] mem_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [35:0] mem_rsp_data_i = '0;
    logic        busy_o, done_o, aborted_o;
    logic [17:0] ea_o;
    logic [7:0]  levels_o;

    logic [35:0] acc [16];
    logic [35:0] mem [64];
    int n_chk = 0, n_fail = 0;
    int rmode = 0;   // 0 fast, 1 random stalls, 2 never ready
    bit finished = 0;

    always #5 clk = ~clk;

    assign acc_data_i = acc[acc_sel_o];

    ea_chain_unit u_ea_chain_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .abort_i(abort_i), .acc_sel_o(acc_sel_o), .acc_data_i(acc_data_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .busy_o(busy_o), .done_o(done_o),
        .aborted_o(aborted_o), .ea_o(ea_o), .levels_o(levels_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] mk(input bit i, input logic [3:0] x,
                                       input logic [17:0] y, input logic [12:0] top);
        return {top, i, x, y};
    endfunction

    // Reference model: walk the chain on the bench tables.
    function automatic void model(input logic [35:0] w, output bit ok,
                                  output logic [17:0] e, output int lv);
        logic [17:0] m;
        ok = 0; e = '0; lv = 0;
        for (int k = 0; k < 64; k++) begin
            m = w[17:0] + ((w[21:18] != 0) ? acc[w[21:18]][17:0] : 18'd0);
            if (!w[22]) begin
                e = m; ok = 1; return;
            end
            w = mem[m[5:0]];
            lv++;
            if (lv > 24) return;
        end
    endfunction

    // Memory responder.
    initial begin
        bit pend = 0;
        int dly = 0;
        logic [17:0] paddr = '0;
        forever begin
            @(negedge clk); #1;
            mem_rsp_valid_i = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = mem[paddr[5:0]];
                    pend = 0;
                end else dly--;
            end
            if (rmode == 0)      mem_req_ready_i = 1'b1;
            else if (rmode == 1) mem_req_ready_i = (($urandom % 4) == 0);
            else                 mem_req_ready_i = 1'b0;
            if (mem_req_valid_o && mem_req_ready_i && !pend) begin
                pend  = 1;
                paddr = mem_addr_o;
                dly   = (rmode == 0) ? 0 : int'($urandom % 4);
            end
        end
    end

    task automatic run_case(input logic [35:0] ins, input int abort_after, input bit poke,
                            output bit got_done, output bit got_abort);
        int cyc;
        @(negedge clk); instr_i = ins; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; cyc = 1;
        got_done = 0; got_abort = 0;
        while (!got_done && !got_abort && cyc < 3000) begin
            if (poke && cyc == 3) begin start_i = 1'b1; instr_i = mk(0, 0, 18'h155, 0); end
            else start_i = 1'b0;
            if (abort_after >= 0 && cyc >= abort_after) abort_i = 1'b1;
            @(negedge clk); cyc++;
            if (done_o) got_done = 1;
            if (aborted_o) got_abort = 1;
        end
        start_i = 1'b0; abort_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit gd, ga, ok;
        logic [17:0] e, prev;
        int lv;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) acc[i] = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 aborted", aborted_o, 0);
        chk("R10 req", mem_req_valid_o, 0);
        chk("R10 ea", ea_o, 0);
        chk("R10 levels", levels_o, 0);

        // R2/R4: unindexed direct word, accumulators full of junk, top bits set (R1)
        for (int i = 0; i < 16; i++) acc[i] = 36'hF_FFFF_FFFF;
        instr_i = mk(0, 0, 18'h12345, 13'h1FFF); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R12 busy after accept", busy_o, 1);
        chk("R4 done not early", done_o, 0);
        @(negedge clk);
        chk("R4 done on second cycle", done_o, 1);
        chk("R2 unindexed E", ea_o, 18'h12345);
        chk("R12 busy falls", busy_o, 0);
        @(negedge clk);
        chk("R4 done one cycle", done_o, 0);
        chk("R8 ea held", ea_o, 18'h12345);

        // R3: index wrap and upper accumulator bits ignored
        acc[5] = {18'h2AAAA, 18'h3FFFF};
        run_case(mk(0, 5, 18'd2, 13'h0A5), -1, 0, gd, ga);
        chk("R3 wrap done", gd, 1);
        chk("R3 wrap E", ea_o, 18'd1);
        chk("R9 no levels direct", levels_o, 0);

        // R7: abort has no effect on a word with the flag clear
        @(negedge clk); instr_i = mk(0, 5, 18'd7, 0); start_i = 1'b1; abort_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk); abort_i = 1'b0;
        chk("R7 abort ignored flag clear done", done_o, 1);
        chk("R7 abort ignored E", ea_o, 18'd6);

        // R5/R11: three-level chain, each level with its own index, slow memory, stray start
        acc[1] = 36'd1; acc[2] = 36'd2; acc[3] = 36'd100;
        mem[20] = mk(1, 2, 18'd28, 13'h1234);
        mem[30] = mk(1, 3, 18'd40 - 18'd100, 0);
        mem[40] = mk(0, 0, 18'o43, 13'h0F0);
        rmode = 1;
        run_case(mk(1, 1, 18'd19, 0), -1, 1, gd, ga);
        chk("R5 chain done", gd, 1);
        chk("R5 chain E", ea_o, 18'o43);
        chk("R9 chain levels", levels_o, 3);
        chk("R11 stray start ignored", ea_o, 18'o43);

        // R7: abort while request waits, memory never ready
        prev = ea_o;
        rmode = 2;
        run_case(mk(1, 0, 18'd50, 0), 6, 0, gd, ga);
        chk("R7 withdraw aborted", ga, 1);
        chk("R7 withdraw no done", gd, 0);
        chk("R7 withdraw ea kept", ea_o, prev);
        chk("R7 withdraw no fetch", levels_o, 0);
        chk("R12 idle after abort", busy_o, 0);

        // R9/R7: self-referencing word, counter saturates, abort breaks the loop
        rmode = 0;
        mem[10] = mk(1, 0, 18'd10, 0);
        run_case(mk(1, 0, 18'd10, 0), 1000, 0, gd, ga);
        chk("R7 loop aborted", ga, 1);
        chk("R7 loop no done", gd, 0);
        chk("R9 saturated", levels_o, 8'hFF);
        chk("R7 loop ea kept", ea_o, prev);

        // Random chains against the model
        for (int t = 0; t < 200; t++) begin
            for (int i = 0; i < 16; i++) acc[i] = 36'({$urandom(), $urandom()});
            for (int i = 0; i < 64; i++)
                mem[i] = mk(($urandom % 4) == 0, ($urandom % 2) ? 4'($urandom) : 4'd0,
                            18'($urandom), 13'($urandom));
            rmode = int'($urandom % 2);
            instr_i = mk($urandom % 2, 4'($urandom), 18'($urandom), 13'($urandom));
            prev = ea_o;
            model(instr_i, ok, e, lv);
            if (ok) begin
                run_case(instr_i, -1, 0, gd, ga);
                chk("R5 random done", gd, 1);
                chk("R3 random E", ea_o, e);
                chk("R9 random levels", levels_o, lv);
            end else begin
                run_case(instr_i, 60, 0, gd, ga);
                chk("R7 random loop aborted", ga, 1);
                chk("R8 random loop ea kept", ea_o, prev);
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule